// File: doc/BRIEF.md
# Receive Ring Buffer Write Engine

This block takes received frames, handed over one dword at a time by an on-chip receive FIFO, and writes them into a circular buffer in system memory. Each frame becomes one record. The record is a 4-byte header followed by the payload, and the next record starts at the following 4-byte boundary. The payload goes out first, at the write pointer plus four. The header is written last: its low half is the 16-bit receive status and its high half is the 16-bit frame length, which counts the CRC. Once the header has been written, the write pointer moves to the start of the next record.

Software owns a read pointer and keeps it 16 bytes behind the position it has really consumed. The engine compares the two pointers to produce a buffer-empty flag and to find out whether the next dword would overrun unread data. When it would, the engine discards the rest of the frame and halts. Two further conditions stop normal storage: a buffer overflow, and an overflow reported by the FIFO. Each has its own recovery sequence, carried out by software through write-one acknowledge strobes. A wrap option decides what happens to a record that runs past the end of the buffer. It either folds back to offset zero, or it continues into spare memory placed after the buffer.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, wr_ptr is 0, the read pointer is buffer size minus 16, buf_empty is 1, all three status bits are 0, rx_ready is 0 and mem_we is 0.
- R2: A frame is started only while rx_valid is high and one of these holds: fifo_eof is 1, or cfg_thresh is a nonzero value k and fifo_bytes is at least 16 shifted left by k. When cfg_thresh is 0, fifo_bytes alone never starts a frame.
- R3: Payload dword i of a frame is written with rx_data unchanged, at byte address wr_ptr + 4 + 4*i.
- R4: After the last payload dword, a single header write goes to address wr_ptr. Its data is rx_len in bits 31:16 and rx_status in bits 15:0.
- R5: wr_ptr then advances by 4 + (rx_len rounded up to a multiple of 4), modulo the buffer size. This happens in the same cycle that the header write appears on the port, and st_rok becomes 1 in that cycle too.
- R6: buf_empty is 1 exactly when (read pointer + 16) modulo the buffer size equals wr_ptr.
- R7: With cfg_wrap at 0, every memory address is reduced modulo the buffer size, so mem_addr bit BUF_LOG2 stays 0.
- R8: With cfg_wrap at 1, payload addresses are not reduced, so a record that crosses the buffer end continues at addresses of buffer size and above.
- R9: The free space is (read pointer + 16 - wr_ptr) modulo the buffer size, with 0 read as the full buffer size. When a payload dword would end at a record offset of that free space or more, it is not written. In that case st_bufovf becomes 1, the rest of the frame is consumed without being written, no header is written, wr_ptr does not change and st_rok is not set.
- R10: After a buffer overflow, no further frame is accepted until software has written the read pointer and then pulsed ack_rok. An ack_rok pulse with no pointer write since the overflow leaves the engine halted.
- R11: A pulse on ack_rok clears st_rok, and a pulse on ack_bufovf clears st_bufovf. Where a set and a clear meet in the same cycle, the set wins.
- R12: A pulse on fifo_ovf_evt sets st_fifoovf. From then on, frames that start are consumed and dropped without any memory write. ack_fifoovf clears only the status bit. Dropping stops only after a pulse on ack_bufovf.
- R13: Every memory address issued is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thresh | input | THR_W | Early start level code; 0 waits for the whole frame |
| cfg_wrap | input | 1 | 1 lets a record run past the buffer end contiguously |
| fifo_bytes | input | FIFO_LOG2+1 | Bytes currently held in the receive FIFO |
| fifo_eof | input | 1 | The FIFO holds the end of the current frame |
| rx_valid | input | 1 | FIFO offers a dword |
| rx_ready | output | 1 | Engine takes the offered dword this cycle |
| rx_data | input | 32 | Payload dword |
| rx_last | input | 1 | Offered dword is the last of the frame |
| rx_len | input | 16 | Frame length in bytes including CRC, valid with rx_last |
| rx_status | input | 16 | Receive status word, valid with rx_last |
| fifo_ovf_evt | input | 1 | Pulse: the receive FIFO overflowed |
| sw_rd_we | input | 1 | Pulse: load the software read pointer |
| sw_rd_ptr | input | BUF_LOG2 | New read pointer value |
| ack_rok | input | 1 | Write-one to the receive-OK status bit |
| ack_bufovf | input | 1 | Write-one to the buffer-overflow status bit |
| ack_fifoovf | input | 1 | Write-one to the FIFO-overflow status bit |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | BUF_LOG2+1 | Byte address within the buffer region |
| mem_wdata | output | 32 | Memory write data |
| wr_ptr | output | BUF_LOG2 | Current write pointer |
| buf_empty | output | 1 | No unread record in the buffer |
| st_rok | output | 1 | A record was completed |
| st_bufovf | output | 1 | A buffer overflow occurred |
| st_fifoovf | output | 1 | A FIFO overflow was reported |

## Verification
The case that is hardest to reach from the ports is a halt partway through a frame. That needs a ring that is almost full, with the overrun landing inside a long frame and not on a record boundary. The stimulus gets there by fixing the read pointer just after a medium record and then offering a frame nearly the size of the buffer. The model then predicts the exact dword at which writing stops. From that halt, the bench first pulses ack_rok alone and holds a frame ready to show that nothing is accepted. It then writes the read pointer and pulses ack_rok again. The two wrap settings are reached with filler records whose length is computed from the model pointer, so that the next record is certain to cross the buffer end.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MOVE = 3'd1,
        ST_HDR  = 3'd2,
        ST_DROP = 3'd3,
        ST_HALT = 3'd4
    } rxr_state_e;

    typedef struct packed {
        logic rok;
        logic bovf;
        logic fovf;
        logic blk;
    } rxr_flags_t;

endpackage

// File: rtl/rxr_start.sv
module rxr_start #(
    parameter int FIFO_LOG2 = 11,
    parameter int THR_W     = 3
) (
    input  logic [THR_W-1:0]   cfg_thresh,
    input  logic [FIFO_LOG2:0] fifo_bytes,
    input  logic               fifo_eof,
    output logic               go
);
    localparam int UNIT = 16;

    logic [31:0] thr_bytes;
    logic        early_hit;

    always_comb begin
        thr_bytes = 32'(UNIT) << cfg_thresh;
        early_hit = (cfg_thresh != '0) && (32'(fifo_bytes) >= thr_bytes);
        go        = fifo_eof || early_hit;
    end
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int AW    = 13,
    parameter int GUARD = 16
) (
    input  logic [AW-1:0] wp,
    input  logic [AW-1:0] rp,
    output logic [AW:0]   free,
    output logic          empty
);
    logic [AW-1:0] tail;
    logic [AW-1:0] gap;

    always_comb begin
        tail  = rp + AW'(GUARD);
        gap   = tail - wp;
        empty = (gap == '0);
        free  = empty ? {1'b1, {AW{1'b0}}} : {1'b0, gap};
    end
endmodule

// File: rtl/rxr_status.sv
module rxr_status
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rok,
    input  logic       set_bovf,
    input  logic       fifo_evt,
    input  logic       ack_rok,
    input  logic       ack_bovf,
    input  logic       ack_fovf,
    output rxr_flags_t flags
);
    rxr_flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (ack_rok)  flg_d.rok = 1'b0;
        if (set_rok)  flg_d.rok = 1'b1;
        if (ack_bovf) begin
            flg_d.bovf = 1'b0;
            flg_d.blk  = 1'b0;
        end
        if (set_bovf) flg_d.bovf = 1'b1;
        if (ack_fovf) flg_d.fovf = 1'b0;
        if (fifo_evt) begin
            flg_d.fovf = 1'b1;
            flg_d.blk  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_LOG2  = 13,
    parameter int FIFO_LOG2 = 11,
    parameter int THR_W     = 3,
    parameter int GUARD     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [THR_W-1:0]    cfg_thresh,
    input  logic                cfg_wrap,
    input  logic [FIFO_LOG2:0]  fifo_bytes,
    input  logic                fifo_eof,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [31:0]         rx_data,
    input  logic                rx_last,
    input  logic [15:0]         rx_len,
    input  logic [15:0]         rx_status,
    input  logic                fifo_ovf_evt,
    input  logic                sw_rd_we,
    input  logic [BUF_LOG2-1:0] sw_rd_ptr,
    input  logic                ack_rok,
    input  logic                ack_bufovf,
    input  logic                ack_fifoovf,
    output logic                mem_we,
    output logic [BUF_LOG2:0]   mem_addr,
    output logic [31:0]         mem_wdata,
    output logic [BUF_LOG2-1:0] wr_ptr,
    output logic                buf_empty,
    output logic                st_rok,
    output logic                st_bufovf,
    output logic                st_fifoovf
);
    localparam int AW        = BUF_LOG2;
    localparam int CW        = AW - 2;
    localparam int BUF_BYTES = 1 << AW;
    localparam logic [AW-1:0] RP_RST = AW'(BUF_BYTES - GUARD);
    localparam logic [AW:0]   HDR_B  = (AW+1)'(4);
    localparam logic [AW:0]   STEP_B = (AW+1)'(8);

    typedef struct packed {
        rxr_state_e    state;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [15:0]   len;
        logic [15:0]   stat;
        logic          halt_after;
        logic          rd_seen;
        logic          mem_we;
        logic [AW:0]   mem_addr;
        logic [31:0]   mem_wdata;
    } core_t;

    core_t      core_d, core_q;
    logic       go;
    logic       empty_w;
    logic [AW:0] free_w;
    logic       set_rok, set_bovf;
    rxr_flags_t flags;
    logic [AW:0] rec_end;
    logic [AW:0] pay_sum;
    logic [AW-1:0] wp_next;
    logic       no_room;

    rxr_start #(.FIFO_LOG2(FIFO_LOG2), .THR_W(THR_W)) u_start (
        .cfg_thresh (cfg_thresh),
        .fifo_bytes (fifo_bytes),
        .fifo_eof   (fifo_eof),
        .go         (go)
    );

    rxr_space #(.AW(AW), .GUARD(GUARD)) u_space (
        .wp    (core_q.wp),
        .rp    (core_q.rp),
        .free  (free_w),
        .empty (empty_w)
    );

    rxr_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_rok  (set_rok),
        .set_bovf (set_bovf),
        .fifo_evt (fifo_ovf_evt),
        .ack_rok  (ack_rok),
        .ack_bovf (ack_bufovf),
        .ack_fovf (ack_fifoovf),
        .flags    (flags)
    );

    // record geometry for the dword now on offer
    always_comb begin
        rec_end = {1'b0, core_q.cnt, 2'b00} + STEP_B;
        pay_sum = {1'b0, core_q.wp} + {1'b0, core_q.cnt, 2'b00} + HDR_B;
        no_room = (rec_end >= free_w);
        wp_next = core_q.wp + AW'(({1'b0, core_q.len} + 17'd7) & ~17'd3);
    end

    always_comb begin
        core_d        = core_q;
        core_d.mem_we = 1'b0;
        set_rok       = 1'b0;
        set_bovf      = 1'b0;

        case (core_q.state)
            ST_IDLE: begin
                if (rx_valid && go) begin
                    core_d.cnt        = '0;
                    core_d.halt_after = 1'b0;
                    core_d.state      = flags.blk ? ST_DROP : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (rx_valid) begin
                    if (no_room) begin
                        set_bovf          = 1'b1;
                        core_d.rd_seen    = 1'b0;
                        core_d.halt_after = 1'b1;
                        core_d.state      = rx_last ? ST_HALT : ST_DROP;
                    end else begin
                        core_d.mem_we    = 1'b1;
                        core_d.mem_addr  = cfg_wrap ? pay_sum : {1'b0, pay_sum[AW-1:0]};
                        core_d.mem_wdata = rx_data;
                        core_d.cnt       = core_q.cnt + 1'b1;
                        if (rx_last) begin
                            core_d.len   = rx_len;
                            core_d.stat  = rx_status;
                            core_d.state = ST_HDR;
                        end
                    end
                end
            end
            ST_HDR: begin
                core_d.mem_we    = 1'b1;
                core_d.mem_addr  = {1'b0, core_q.wp};
                core_d.mem_wdata = {core_q.len, core_q.stat};
                core_d.wp        = wp_next;
                set_rok          = 1'b1;
                core_d.state     = ST_IDLE;
            end
            ST_DROP: begin
                if (rx_valid && rx_last)
                    core_d.state = core_q.halt_after ? ST_HALT : ST_IDLE;
            end
            ST_HALT: begin
                if (ack_rok && core_q.rd_seen)
                    core_d.state = ST_IDLE;
            end
            default: core_d.state = ST_IDLE;
        endcase

        if (sw_rd_we) begin
            core_d.rp      = sw_rd_ptr;
            core_d.rd_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.rp <= RP_RST;
        end else begin
            core_q <= core_d;
        end
    end

    assign rx_ready   = (core_q.state == ST_MOVE) || (core_q.state == ST_DROP);
    assign mem_we     = core_q.mem_we;
    assign mem_addr   = core_q.mem_addr;
    assign mem_wdata  = core_q.mem_wdata;
    assign wr_ptr     = core_q.wp;
    assign buf_empty  = empty_w;
    assign st_rok     = flags.rok;
    assign st_bufovf  = flags.bovf;
    assign st_fifoovf = flags.fovf;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wrap,
    input logic          sw_rd_we,
    input logic          ack_rok,
    input logic          mem_we,
    input logic [AW:0]   mem_addr,
    input logic [AW-1:0] wr_ptr,
    input logic          buf_empty,
    input logic          st_rok,
    input logic          st_bufovf
);
    // R13
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) |-> (st_rok && mem_we));

    // R6
    empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> (!$stable(wr_ptr) || $past(sw_rd_we)));

    // R7
    fold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(cfg_wrap)) |-> !mem_addr[AW]);

    // R9
    ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_bufovf) |-> !mem_we);

    // R11
    rok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rok |=> (!st_rok || !$stable(wr_ptr)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(BUF_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wrap  (cfg_wrap),
    .sw_rd_we  (sw_rd_we),
    .ack_rok   (ack_rok),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .wr_ptr    (wr_ptr),
    .buf_empty (buf_empty),
    .st_rok    (st_rok),
    .st_bufovf (st_bufovf)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
    localparam int BUF_LOG2  = 10;
    localparam int FIFO_LOG2 = 11;
    localparam int THR_W     = 3;
    localparam int AW        = BUF_LOG2;
    localparam int S         = 1 << BUF_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [THR_W-1:0] cfg_thresh = '0;
    logic cfg_wrap = 1'b0;
    logic [FIFO_LOG2:0] fifo_bytes = '0;
    logic fifo_eof = 1'b1;
    logic rx_valid = 1'b0, rx_ready, rx_last = 1'b0;
    logic [31:0] rx_data = '0;
    logic [15:0] rx_len = '0, rx_status = '0;
    logic fifo_ovf_evt = 1'b0, sw_rd_we = 1'b0;
    logic [AW-1:0] sw_rd_ptr = '0;
    logic ack_rok = 1'b0, ack_bufovf = 1'b0, ack_fifoovf = 1'b0;
    logic mem_we;
    logic [AW:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [AW-1:0] wr_ptr;
    logic buf_empty, st_rok, st_bufovf, st_fifoovf;

    always #10 clk = ~clk;

    rx_ring_writer #(.BUF_LOG2(BUF_LOG2), .FIFO_LOG2(FIFO_LOG2), .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_wrap(cfg_wrap),
        .fifo_bytes(fifo_bytes), .fifo_eof(fifo_eof), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_len(rx_len),
        .rx_status(rx_status), .fifo_ovf_evt(fifo_ovf_evt), .sw_rd_we(sw_rd_we),
        .sw_rd_ptr(sw_rd_ptr), .ack_rok(ack_rok), .ack_bufovf(ack_bufovf),
        .ack_fifoovf(ack_fifoovf), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .buf_empty(buf_empty),
        .st_rok(st_rok), .st_bufovf(st_bufovf), .st_fifoovf(st_fifoovf)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int wp_m = 0;
    int rp_m = S - 16;
    int max_addr = 0;
    logic [AW:0]  qa[$];
    logic [31:0]  qd[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every-clock comparison of the memory port against the model's queue
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (int'(mem_addr) > max_addr) max_addr = int'(mem_addr);
            if (qa.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3 unexpected write: actual addr %0h expected no write", mem_addr);
            end else begin
                check("R3 or R4 address", 32'(mem_addr), 32'(qa[0]));
                check("R3 or R4 data", mem_wdata, qd[0]);
                void'(qa.pop_front());
                void'(qd.pop_front());
            end
        end
    end

    task automatic model(int len, logic [15:0] st, logic [31:0] seed, bit drop, output bit ovf);
        int n;
        int fr;
        n = (len + 3) / 4;
        ovf = 0;
        if (drop) return;
        fr = (rp_m + 16 - wp_m) & (S - 1);
        if (fr == 0) fr = S;
        for (int i = 0; i < n; i++) begin
            int a;
            if (8 + 4 * i >= fr) begin
                ovf = 1;
                break;
            end
            a = wp_m + 4 + 4 * i;
            if (!cfg_wrap) a = a & (S - 1);
            qa.push_back((AW+1)'(a));
            qd.push_back(seed + 32'(i));
        end
        if (!ovf) begin
            qa.push_back((AW+1)'(wp_m));
            qd.push_back({16'(len), st});
            wp_m = (wp_m + 4 + 4 * n) & (S - 1);
        end
    endtask

    task automatic send(int len, logic [15:0] st, logic [31:0] seed);
        int n;
        int i;
        n = (len + 3) / 4;
        i = 0;
        rx_len = 16'(len);
        rx_status = st;
        while (i < n) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = seed + 32'(i);
            rx_last = (i == n - 1);
            if (rx_ready) i++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(int len, logic [15:0] st, logic [31:0] seed, bit drop, output bit ovf);
        model(len, st, seed, drop, ovf);
        send(len, st, seed);
    endtask

    task automatic set_rd(int val);
        @(negedge clk);
        sw_rd_ptr = AW'(val);
        sw_rd_we = 1'b1;
        rp_m = val & (S - 1);
        @(negedge clk);
        sw_rd_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: ack_rok = 1'b1;
            1: ack_bufovf = 1'b1;
            2: ack_fifoovf = 1'b1;
            default: fifo_ovf_evt = 1'b1;
        endcase
        @(negedge clk);
        ack_rok = 1'b0;
        ack_bufovf = 1'b0;
        ack_fifoovf = 1'b0;
        fifo_ovf_evt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bit ovf;
        int hold_wp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 wr_ptr", 32'(wr_ptr), 0);
        check("R1 buf_empty", 32'(buf_empty), 1);
        check("R1 st_rok", 32'(st_rok), 0);
        check("R1 st_bufovf", 32'(st_bufovf), 0);
        check("R1 st_fifoovf", 32'(st_fifoovf), 0);
        check("R1 rx_ready", 32'(rx_ready), 0);
        check("R1 mem_we", 32'(mem_we), 0);

        // R3 R4 R5: odd length rounds up to a dword boundary
        frame(61, 16'h0001, 32'h1000_0000, 0, ovf);
        check("R5 wr_ptr after 61-byte frame", 32'(wr_ptr), 68);
        check("R5 st_rok set", 32'(st_rok), 1);
        check("R6 buf_empty cleared", 32'(buf_empty), 0);
        pulse(0);
        check("R11 st_rok cleared by ack", 32'(st_rok), 0);
        frame(64, 16'h2001, 32'h2000_0000, 0, ovf);
        check("R5 wr_ptr after 64-byte frame", 32'(wr_ptr), 136);

        // R6 read pointer catches up
        set_rd(wp_m - 16);
        check("R6 buf_empty when caught up", 32'(buf_empty), 1);

        // R2 early threshold: code 3 means 128 bytes
        cfg_thresh = 3'd3;
        fifo_eof = 1'b0;
        fifo_bytes = 12'd100;
        @(negedge clk);
        rx_valid = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 below threshold no start", 32'(rx_ready), 0);
        fifo_bytes = 12'd128;
        frame(128, 16'h4001, 32'h3000_0000, 0, ovf);
        check("R2 started at threshold", 32'(wr_ptr), 268);

        // R2 no-early mode waits for the frame end
        cfg_thresh = '0;
        fifo_bytes = 12'd2048;
        @(negedge clk);
        rx_valid = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 no-early full FIFO no start", 32'(rx_ready), 0);
        fifo_eof = 1'b1;
        frame(20, 16'h8001, 32'h4000_0000, 0, ovf);
        check("R2 started on frame end", 32'(wr_ptr), 292);

        // R7 folded crossing
        set_rd(wp_m - 16);
        frame(S - wp_m - 104, 16'h0001, 32'h5000_0000, 0, ovf);
        set_rd(wp_m - 16);
        cfg_wrap = 1'b0;
        max_addr = 0;
        frame(200, 16'h0001, 32'h6000_0000, 0, ovf);
        check("R7 wr_ptr after folded record", 32'(wr_ptr), 104);
        check("R7 no address past buffer end", 32'(max_addr < S), 1);

        // R8 contiguous crossing
        set_rd(wp_m - 16);
        frame(S - wp_m - 104, 16'h0001, 32'h7000_0000, 0, ovf);
        set_rd(wp_m - 16);
        cfg_wrap = 1'b1;
        max_addr = 0;
        frame(200, 16'h0001, 32'h8000_0000, 0, ovf);
        check("R8 wr_ptr after contiguous record", 32'(wr_ptr), 104);
        check("R8 address past buffer end used", 32'(max_addr >= S), 1);
        cfg_wrap = 1'b0;

        // R9 overflow in the middle of a long frame
        set_rd(wp_m - 16);
        frame(400, 16'h0001, 32'h9000_0000, 0, ovf);
        pulse(0);
        hold_wp = wp_m;
        frame(1000, 16'h0001, 32'hA000_0000, 0, ovf);
        check("R9 model predicts overflow", 32'(ovf), 1);
        check("R9 st_bufovf set", 32'(st_bufovf), 1);
        check("R9 st_rok not set", 32'(st_rok), 0);
        check("R9 wr_ptr unchanged", 32'(wr_ptr), 32'(hold_wp));

        // R10 ack without a pointer update keeps the halt
        pulse(0);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_last = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 halted after ack alone", 32'(rx_ready), 0);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        set_rd(wp_m - 16);
        repeat (3) @(negedge clk);
        check("R10 halted after pointer update alone", 32'(rx_ready), 0);
        pulse(0);
        frame(100, 16'h0001, 32'hB000_0000, 0, ovf);
        check("R10 resumed wr_ptr", 32'(wr_ptr), 32'(wp_m));
        check("R10 resumed st_rok", 32'(st_rok), 1);

        // R11 buffer-overflow status clear
        pulse(1);
        check("R11 st_bufovf cleared", 32'(st_bufovf), 0);

        // R12 FIFO overflow drop and its recovery
        pulse(0);
        pulse(3);
        check("R12 st_fifoovf set", 32'(st_fifoovf), 1);
        hold_wp = wp_m;
        frame(40, 16'h0001, 32'hC000_0000, 1, ovf);
        check("R12 frame dropped wr_ptr", 32'(wr_ptr), 32'(hold_wp));
        check("R12 frame dropped st_rok", 32'(st_rok), 0);
        pulse(2);
        check("R12 st_fifoovf cleared", 32'(st_fifoovf), 0);
        frame(40, 16'h0001, 32'hD000_0000, 1, ovf);
        check("R12 still dropping after status clear", 32'(wr_ptr), 32'(hold_wp));
        pulse(1);
        frame(40, 16'h0001, 32'hE000_0000, 0, ovf);
        check("R12 stored after buffer-overflow ack", 32'(wr_ptr), 32'(hold_wp + 44));
        check("R12 st_rok after recovery", 32'(st_rok), 1);

        check("R3 all expected writes seen", 32'(qa.size()), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule